// File: doc/BRIEF.md
# Flash Command Sequencer

This block is a synchronous model of the command front end of a parallel NOR flash. A host writes command cycles to it, each an address and a byte. The block decodes these cycles and picks what a read returns: the array contents, the identifier codes or the status byte. It also launches block erase, byte program and lock configuration operations into a small write engine. The busy time of that engine is a cycle count supplied on an input port.

Erase and program operations reach the storage array through a request channel. The array sits outside the block, so the block only sends it a request and returns whatever byte the array supplies for the current read address. Setup commands that need a confirm byte are guarded in two ways. A wrong second byte sets sticky error flags, and commands that would disturb a running or suspended operation are refused. Driving the active-low reset pin low aborts all work and puts the block in its power-up state.

The host command channel uses valid/ready. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. This models the moment when the first of the write strobe or the chip enable rises. `cmd_ready` is low while an array request is still waiting, so the host must hold the command stable until it is taken. The array request channel is also valid/ready. Once `op_valid` is raised, it and the request fields stay unchanged until the array takes the request with `op_ready`.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, reads return array data (`rd_data` follows `arr_rdata`) and the status byte is 80h. Status bit 7 means ready, bits 6 and 2 mean erase or program suspended, and bits 5, 4, 3 and 1 are error flags.
- R2: Byte FFh selects array reads, 90h selects identifier reads and 70h selects status reads. The mode holds until another accepted command changes it. In identifier mode, address 0 returns `MFR_CODE`, address 1 returns `DEV_CODE` and every other address returns 00h.
- R3: A byte outside the set {FFh, 90h, 70h, 50h, 20h, 40h, 10h, 60h, B0h, D0h} is ignored when no confirm byte is expected, and the read mode does not change.
- R4: The pair 20h then D0h starts a block erase. The erase request carries the address with its low `BLK_W` bits cleared, so every byte of that block becomes FFh.
- R5: The pair 40h or 10h then a data byte starts a byte program of that byte at the address of the second cycle.
- R6: A second cycle that is not a valid confirm sets status bits 5 and 4, and no operation starts. For erase the valid confirm is D0h; for lock setup (60h) it is 01h, F1h or D0h.
- R7: Once a setup byte (20h, 40h, 10h or 60h) has been accepted, reads return the status byte without any 70h command.
- R8: Status bit 7 stays clear while the engine works. For a lock operation this lasts max(`busy_cycles`,1) cycles after the confirm is taken. For an erase or program it lasts one cycle longer, plus the cycles the array holds `op_ready` low.
- R9: While the engine runs and is not suspended, FFh is ignored and setup bytes are refused. A byte after a refused setup byte is decoded as a new command.
- R10: B0h suspends a running erase or program. The busy count freezes, and status shows bit 7 together with bit 6 (erase) or bit 2 (program). D0h resumes the operation, clears those bits and clears bit 7.
- R11: Error bits stay set until 50h is accepted. 50h has no effect while an operation is suspended.
- R12: If `prog_inhibit` is high when a valid confirm arrives, no operation starts. Status bit 3 is set, together with bit 5 for an erase or bit 4 for a program or lock.
- R13: Driving `rst_n` low during an operation aborts it, returns reads to array mode and loads status with 80h.
- R14: While an array request waits for `op_ready`, `cmd_ready` is low, and the request holds its address and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down, asynchronous |
| cmd_valid | input | 1 | Host command cycle present |
| cmd_ready | output | 1 | Command cycle can be taken |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | 8 | Command or data byte |
| busy_cycles | input | CNT_W | Engine busy time in cycles (0 treated as 1) |
| prog_inhibit | input | 1 | Programming supply absent |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data for the current mode |
| arr_rdata | input | 8 | Array byte at `rd_addr` |
| op_valid | output | 1 | Array request pending |
| op_ready | input | 1 | Array takes the request |
| op_erase | output | 1 | 1: block erase, 0: byte program |
| op_addr | output | ADDR_W | Request address (block base for erase) |
| op_data | output | 8 | Byte to program |

## Verification
The bench builds the block with an 8-bit address, 16-byte blocks and an 8-bit busy counter. This makes the array only 256 bytes, so it can be compared byte for byte after erases and programs. Every one of the 256 possible command bytes is applied from the reset state, and the read result is checked against the decode rules. Busy counts of 0 to 13 and a stalled array request are used to check the exact ready latency of program and lock operations. A suspend placed in the middle of an operation checks that the remaining count is frozen while suspended and finishes correctly after resume.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [3:0] {
    CMD_NONE,
    CMD_RD_ARRAY,
    CMD_RD_ID,
    CMD_RD_STAT,
    CMD_CLR_STAT,
    CMD_ERASE_SETUP,
    CMD_WRITE_SETUP,
    CMD_LOCK_SETUP,
    CMD_SUSPEND,
    CMD_CONFIRM
  } cmd_e;

  typedef enum logic [1:0] {
    SETUP_NONE  = 2'd0,
    SETUP_ERASE = 2'd1,
    SETUP_WRITE = 2'd2,
    SETUP_LOCK  = 2'd3
  } setup_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_SUSP = 2'd2
  } eng_e;

  localparam logic [7:0] OPC_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] OPC_RD_ID     = 8'h90;
  localparam logic [7:0] OPC_RD_STAT   = 8'h70;
  localparam logic [7:0] OPC_CLR_STAT  = 8'h50;
  localparam logic [7:0] OPC_ERASE     = 8'h20;
  localparam logic [7:0] OPC_WRITE_A   = 8'h40;
  localparam logic [7:0] OPC_WRITE_B   = 8'h10;
  localparam logic [7:0] OPC_LOCK      = 8'h60;
  localparam logic [7:0] OPC_SUSPEND   = 8'hB0;
  localparam logic [7:0] OPC_CONFIRM   = 8'hD0;
  localparam logic [7:0] OPC_LOCK_BLK  = 8'h01;
  localparam logic [7:0] OPC_LOCK_MST  = 8'hF1;

  localparam int ST_READY    = 7;
  localparam int ST_ERS_SUSP = 6;
  localparam int ST_ERS_ERR  = 5;
  localparam int ST_PRG_ERR  = 4;
  localparam int ST_SUP_ERR  = 3;
  localparam int ST_PRG_SUSP = 2;
  localparam int ST_LCK_ERR  = 1;

  localparam logic [7:0] ST_RESET = 8'h80;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_cmd_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_e       cmd_o
);

  always_comb begin
    case (byte_i)
      OPC_RD_ARRAY:             cmd_o = CMD_RD_ARRAY;
      OPC_RD_ID:                cmd_o = CMD_RD_ID;
      OPC_RD_STAT:              cmd_o = CMD_RD_STAT;
      OPC_CLR_STAT:             cmd_o = CMD_CLR_STAT;
      OPC_ERASE:                cmd_o = CMD_ERASE_SETUP;
      OPC_WRITE_A, OPC_WRITE_B: cmd_o = CMD_WRITE_SETUP;
      OPC_LOCK:                 cmd_o = CMD_LOCK_SETUP;
      OPC_SUSPEND:              cmd_o = CMD_SUSPEND;
      OPC_CONFIRM:              cmd_o = CMD_CONFIRM;
      default:                  cmd_o = CMD_NONE;
    endcase
  end

endmodule

// File: rtl/nor_wr_engine.sv
module nor_wr_engine
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_array_op,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_data,
  input  logic              suspend,
  input  logic              resume,
  input  logic [CNT_W-1:0]  busy_cycles,
  input  logic              op_ready,
  output logic              op_valid,
  output logic              op_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              running,
  output logic              suspended,
  output logic              done
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  eng_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] req_addr;

  // Erase requests point at the block base.
  always_comb begin
    req_addr = start_addr;
    if (start_erase) req_addr[BLK_W-1:0] = '0;
  end

  assign running   = (state_q == ENG_RUN);
  assign suspended = (state_q == ENG_SUSP);
  assign done      = running && !suspend && !op_valid && (cnt_q <= CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      cnt_q    <= '0;
      op_valid <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else if (start) begin
      state_q  <= ENG_RUN;
      cnt_q    <= (busy_cycles == '0) ? CNT_ONE : busy_cycles;
      op_valid <= start_array_op;
      op_erase <= start_erase;
      op_addr  <= req_addr;
      op_data  <= start_data;
    end else begin
      case (state_q)
        ENG_RUN: begin
          if (suspend)                 state_q  <= ENG_SUSP;
          else if (op_valid) begin
            if (op_ready)              op_valid <= 1'b0;
          end else if (cnt_q <= CNT_ONE) state_q <= ENG_IDLE;
          else                         cnt_q    <= cnt_q - CNT_ONE;
        end
        ENG_SUSP: if (resume) state_q <= ENG_RUN;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nor_rd_mux.sv
module nor_rd_mux
  import nor_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 20,
  parameter int         BLK_W    = 16,
  parameter logic [7:0] MFR_CODE = 8'hB0,
  parameter logic [7:0] DEV_CODE = 8'hA2
) (
  input  rd_mode_e          mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  input  logic [7:0]        status,
  output logic [7:0]        rd_data
);

  logic base_blk;
  logic [BLK_W-1:0] offs;

  assign base_blk = (rd_addr[ADDR_W-1:BLK_W] == '0);
  assign offs     = rd_addr[BLK_W-1:0];

  always_comb begin
    case (mode)
      MODE_IDENT: begin
        if (base_blk && offs == BLK_W'(0))      rd_data = MFR_CODE;
        else if (base_blk && offs == BLK_W'(1)) rd_data = DEV_CODE;
        else                                    rd_data = 8'h00;
      end
      MODE_STATUS: rd_data = status;
      default:     rd_data = arr_rdata;
    endcase
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 20,
  parameter int         BLK_W    = 16,
  parameter int         CNT_W    = 16,
  parameter logic [7:0] MFR_CODE = 8'hB0,
  parameter logic [7:0] DEV_CODE = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [CNT_W-1:0]  busy_cycles,
  input  logic              prog_inhibit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [7:0]        arr_rdata,
  output logic              op_valid,
  input  logic              op_ready,
  output logic              op_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  rd_mode_e   mode_q;
  setup_e     setup_q;
  setup_e     run_q;
  logic [7:0] status_q;
  cmd_e       cmd;
  logic       fire, second, confirm_ok, start;
  logic       suspend_req, resume_req;
  logic       eng_running, eng_suspended, eng_done, eng_idle;

  assign cmd_ready = !op_valid;
  assign fire      = cmd_valid && cmd_ready;
  assign second    = fire && (setup_q != SETUP_NONE);
  assign eng_idle  = !eng_running && !eng_suspended;

  nor_cmd_decode u_dec (
    .byte_i (cmd_data),
    .cmd_o  (cmd)
  );

  always_comb begin
    case (setup_q)
      SETUP_ERASE: confirm_ok = (cmd_data == OPC_CONFIRM);
      SETUP_WRITE: confirm_ok = 1'b1;
      SETUP_LOCK:  confirm_ok = (cmd_data == OPC_LOCK_BLK) ||
                                (cmd_data == OPC_LOCK_MST) ||
                                (cmd_data == OPC_CONFIRM);
      default:     confirm_ok = 1'b0;
    endcase
  end

  assign start       = second && confirm_ok && !prog_inhibit;
  assign suspend_req = fire && (setup_q == SETUP_NONE) && (cmd == CMD_SUSPEND) &&
                       eng_running && (run_q != SETUP_LOCK);
  assign resume_req  = fire && (setup_q == SETUP_NONE) && (cmd == CMD_CONFIRM) &&
                       eng_suspended;

  nor_wr_engine #(
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W),
    .CNT_W  (CNT_W)
  ) u_eng (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .start_array_op (setup_q != SETUP_LOCK),
    .start_erase    (setup_q == SETUP_ERASE),
    .start_addr     (cmd_addr),
    .start_data     (cmd_data),
    .suspend        (suspend_req),
    .resume         (resume_req),
    .busy_cycles    (busy_cycles),
    .op_ready       (op_ready),
    .op_valid       (op_valid),
    .op_erase       (op_erase),
    .op_addr        (op_addr),
    .op_data        (op_data),
    .running        (eng_running),
    .suspended      (eng_suspended),
    .done           (eng_done)
  );

  nor_rd_mux #(
    .ADDR_W   (ADDR_W),
    .BLK_W    (BLK_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_mux (
    .mode      (mode_q),
    .rd_addr   (rd_addr),
    .arr_rdata (arr_rdata),
    .status    (status_q),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_ARRAY;
      setup_q  <= SETUP_NONE;
      run_q    <= SETUP_NONE;
      status_q <= ST_RESET;
    end else begin
      if (eng_done) status_q[ST_READY] <= 1'b1;
      if (second) begin
        setup_q <= SETUP_NONE;
        mode_q  <= MODE_STATUS;
        if (!confirm_ok) begin
          status_q[ST_ERS_ERR] <= 1'b1;
          status_q[ST_PRG_ERR] <= 1'b1;
        end else if (prog_inhibit) begin
          status_q[ST_SUP_ERR] <= 1'b1;
          if (setup_q == SETUP_ERASE) status_q[ST_ERS_ERR] <= 1'b1;
          else                        status_q[ST_PRG_ERR] <= 1'b1;
        end else begin
          status_q[ST_READY] <= 1'b0;
          run_q              <= setup_q;
        end
      end else if (fire) begin
        case (cmd)
          CMD_RD_ARRAY: if (!eng_running) mode_q <= MODE_ARRAY;
          CMD_RD_ID:    mode_q <= MODE_IDENT;
          CMD_RD_STAT:  mode_q <= MODE_STATUS;
          CMD_CLR_STAT: if (!eng_suspended) begin
            status_q[ST_ERS_ERR] <= 1'b0;
            status_q[ST_PRG_ERR] <= 1'b0;
            status_q[ST_SUP_ERR] <= 1'b0;
            status_q[ST_LCK_ERR] <= 1'b0;
          end
          CMD_ERASE_SETUP: if (eng_idle) begin
            setup_q <= SETUP_ERASE;
            mode_q  <= MODE_STATUS;
          end
          CMD_WRITE_SETUP: if (eng_idle) begin
            setup_q <= SETUP_WRITE;
            mode_q  <= MODE_STATUS;
          end
          CMD_LOCK_SETUP: if (eng_idle) begin
            setup_q <= SETUP_LOCK;
            mode_q  <= MODE_STATUS;
          end
          CMD_SUSPEND: if (suspend_req) begin
            mode_q             <= MODE_STATUS;
            status_q[ST_READY] <= 1'b1;
            if (run_q == SETUP_ERASE) status_q[ST_ERS_SUSP] <= 1'b1;
            else                      status_q[ST_PRG_SUSP] <= 1'b1;
          end
          CMD_CONFIRM: if (resume_req) begin
            mode_q                <= MODE_STATUS;
            status_q[ST_READY]    <= 1'b0;
            status_q[ST_ERS_SUSP] <= 1'b0;
            status_q[ST_PRG_SUSP] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_data,
  input logic              op_valid,
  input logic              op_ready,
  input logic              op_erase,
  input logic [ADDR_W-1:0] op_addr,
  input logic [7:0]        status_q,
  input rd_mode_e          mode_q,
  input setup_e            setup_q,
  input logic              eng_running,
  input logic              eng_suspended
);

  // R14: a waiting array request keeps its contents
  assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_addr) && $stable(op_erase));

  // R8: ready flag is clear whenever the engine is counting
  assert_busy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_running |-> !status_q[ST_READY]);

  // R10: a suspended engine reports ready plus one suspend flag
  assert_susp_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_suspended |-> status_q[ST_READY] &&
                      (status_q[ST_ERS_SUSP] || status_q[ST_PRG_SUSP]));

  // R11: erase error flag only falls through an accepted clear command
  assert_sticky_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[ST_ERS_ERR] && !(cmd_valid && cmd_ready && cmd_data == OPC_CLR_STAT)
    |=> status_q[ST_ERS_ERR]);

  // R9: array read request is dropped while the engine runs
  assert_ff_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_running && cmd_valid && cmd_ready && cmd_data == OPC_RD_ARRAY &&
    setup_q == SETUP_NONE |=> mode_q != MODE_ARRAY);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_data      (cmd_data),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .op_erase      (op_erase),
  .op_addr       (op_addr),
  .status_q      (status_q),
  .mode_q        (mode_q),
  .setup_q       (setup_q),
  .eng_running   (eng_running),
  .eng_suspended (eng_suspended)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;

  localparam int         CLK_PERIOD = 10;
  localparam int         AW   = 8;
  localparam int         BW   = 4;
  localparam int         CW   = 8;
  localparam logic [7:0] MFR  = 8'h3C;
  localparam logic [7:0] DEV  = 8'hE8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic [CW-1:0] busy_cycles = 8'd3;
  logic          prog_inhibit = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic [7:0]    arr_rdata;
  logic          op_valid, op_ready, op_erase;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic       load_mem = 1'b1;
  logic [7:0] wait_cnt;
  int         stall = 0;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(
    .ADDR_W(AW), .BLK_W(BW), .CNT_W(CW), .MFR_CODE(MFR), .DEV_CODE(DEV)
  ) u_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy_cycles(busy_cycles),
    .prog_inhibit(prog_inhibit), .rd_addr(rd_addr), .rd_data(rd_data),
    .arr_rdata(arr_rdata), .op_valid(op_valid), .op_ready(op_ready),
    .op_erase(op_erase), .op_addr(op_addr), .op_data(op_data)
  );

  // Array model
  assign arr_rdata = mem[rd_addr];
  assign op_ready  = op_valid && (int'(wait_cnt) >= stall);

  always @(posedge clk) begin
    wait_cnt <= (op_valid && !op_ready) ? wait_cnt + 8'd1 : 8'd0;
    if (load_mem) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (op_valid && op_ready) begin
      if (op_erase) begin
        for (int i = 0; i < 16; i++) mem[{op_addr[7:4], 4'(i)}] <= 8'hFF;
      end else begin
        mem[op_addr] <= op_data;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    #1;
    while (rd_data[7] == 1'b0 && n < 5000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [7:0] single_exp(input logic [7:0] b, input logic [7:0] arr);
    case (b)
      8'h90:                      return DEV;     // address 1 in identifier mode
      8'h70, 8'h20, 8'h40,
      8'h10, 8'h60:               return 8'h80;   // status
      default:                    return arr;     // array mode kept
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
    repeat (2) @(negedge clk);
    load_mem = 1'b0;
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h21, v); chk("R1 array after reset", v, exp_mem[8'h21]);
    chk("R1 cmd_ready idle", {7'd0, cmd_ready}, 8'h01);
    wr(8'h00, 8'h70); rd(8'h00, v); chk("R1 status after reset", v, 8'h80);

    // R2/R3/R7: every byte from the reset state
    for (int b = 0; b < 256; b++) begin
      do_reset();
      wr(8'h00, 8'(b));
      rd(8'h01, v);
      chk($sformatf("R3 R2 R7 single byte %h", b[7:0]), v, single_exp(8'(b), exp_mem[1]));
    end

    // R2: identifier map and persistence; R3 undefined byte in ident mode
    do_reset();
    wr(8'h00, 8'h90);
    rd(8'h00, v); chk("R2 ident mfr", v, MFR);
    rd(8'h01, v); chk("R2 ident dev", v, DEV);
    rd(8'h02, v); chk("R2 ident other", v, 8'h00);
    rd(8'h10, v); chk("R2 ident block1", v, 8'h00);
    wr(8'h00, 8'h33);
    rd(8'h01, v); chk("R3 undefined keeps ident", v, DEV);
    wr(8'h00, 8'hFF);
    rd(8'h01, v); chk("R2 back to array", v, exp_mem[1]);

    // R4: block erase
    busy_cycles = 8'd4;
    wr(8'h35, 8'h20); rd(8'h00, v); chk("R7 status after erase setup", v, 8'h80);
    wr(8'h35, 8'hD0);
    wait_ready(n); chk("R8 erase latency", 8'(n), 8'd5);
    for (int i = 8'h30; i < 8'h40; i++) exp_mem[i] = 8'hFF;
    wr(8'h00, 8'hFF);
    for (int i = 0; i < 256; i++) begin
      rd(8'(i), v); chk($sformatf("R4 erase byte %h", i[7:0]), v, exp_mem[i]);
    end

    // R5: byte programs with both setup codes
    wr(8'h47, 8'h40); wr(8'h47, 8'h12); wait_ready(n);
    wr(8'h48, 8'h10); wr(8'h48, 8'h34); wait_ready(n);
    exp_mem[8'h47] = 8'h12; exp_mem[8'h48] = 8'h34;
    rd(8'h00, v); chk("R5 status after program", v, 8'h80);
    wr(8'h00, 8'hFF);
    rd(8'h47, v); chk("R5 program 40h", v, 8'h12);
    rd(8'h48, v); chk("R5 program 10h", v, 8'h34);

    // R8: latency sweep for program and lock
    for (int k = 0; k < 14; k++) begin
      busy_cycles = 8'(k);
      wr(8'(8'h80 + k), 8'h40); wr(8'(8'h80 + k), 8'(k) ^ 8'hC3);
      exp_mem[8'h80 + k] = 8'(k) ^ 8'hC3;
      wait_ready(n);
      chk($sformatf("R8 program latency busy=%0d", k), 8'(n), 8'((k == 0 ? 1 : k) + 1));
    end
    busy_cycles = 8'd5;
    wr(8'h00, 8'h60); wr(8'h00, 8'h01); wait_ready(n);
    chk("R8 lock latency", 8'(n), 8'd5);
    busy_cycles = 8'd0;
    wr(8'h00, 8'h60); wr(8'h00, 8'hF1); wait_ready(n);
    chk("R8 lock latency zero", 8'(n), 8'd1);
    rd(8'h00, v); chk("R8 status after lock", v, 8'h80);

    // R14: stalled array request back-pressures commands
    stall = 3; busy_cycles = 8'd4;
    wr(8'h90, 8'h40); wr(8'h90, 8'h66);
    chk("R14 cmd_ready low while request waits", {7'd0, cmd_ready}, 8'h00);
    chk("R14 request pending", {7'd0, op_valid}, 8'h01);
    wait_ready(n); chk("R8 R14 latency with stall", 8'(n), 8'd8);
    exp_mem[8'h90] = 8'h66;
    stall = 0;

    // R6: bad confirms
    wr(8'h00, 8'h50);
    wr(8'h20, 8'h20); wr(8'h20, 8'h55);
    chk("R6 no request on bad confirm", {7'd0, op_valid}, 8'h00);
    rd(8'h00, v); chk("R6 erase bad confirm", v, 8'hB0);
    wr(8'h00, 8'h50); rd(8'h00, v); chk("R11 clear", v, 8'h80);
    wr(8'h00, 8'h60); wr(8'h00, 8'h22);
    rd(8'h00, v); chk("R6 lock bad confirm", v, 8'hB0);

    // R10/R11: suspend of a program with sticky errors present
    busy_cycles = 8'd10;
    wr(8'h22, 8'h40); wr(8'h22, 8'h99);
    exp_mem[8'h22] = 8'h99;
    rd(8'h00, v); chk("R11 errors kept while busy", v, 8'h30);
    repeat (3) @(negedge clk);
    wr(8'h00, 8'hB0);
    rd(8'h00, v); chk("R10 program suspended", v, 8'hB4);
    repeat (15) @(negedge clk);
    rd(8'h00, v); chk("R10 stays suspended", v, 8'hB4);
    wr(8'h00, 8'h50);
    rd(8'h00, v); chk("R11 clear ignored in suspend", v, 8'hB4);
    wr(8'h00, 8'hFF);
    rd(8'h22, v); chk("R10 array read in suspend", v, 8'h99);
    wr(8'h00, 8'hD0);
    rd(8'h00, v); chk("R10 resumed", v, 8'h30);
    wait_ready(n); chk("R10 remaining count frozen", 8'(n), 8'd7);
    rd(8'h00, v); chk("R11 errors after finish", v, 8'hB0);
    wr(8'h00, 8'h50); rd(8'h00, v); chk("R11 clear after finish", v, 8'h80);

    // R10: erase suspend flag
    wr(8'h55, 8'h20); wr(8'h55, 8'hD0);
    for (int i = 8'h50; i < 8'h60; i++) exp_mem[i] = 8'hFF;
    repeat (2) @(negedge clk);
    wr(8'h00, 8'hB0);
    rd(8'h00, v); chk("R10 erase suspended", v, 8'hC0);
    wr(8'h00, 8'hD0); wait_ready(n);
    rd(8'h00, v); chk("R10 erase done", v, 8'h80);

    // R9: array read and setup refused while running
    busy_cycles = 8'd20;
    wr(8'h60, 8'h20); wr(8'h60, 8'hD0);
    for (int i = 8'h60; i < 8'h70; i++) exp_mem[i] = 8'hFF;
    wr(8'h00, 8'hFF);
    rd(8'h00, v); chk("R9 FF ignored while running", v, 8'h00);
    wr(8'h10, 8'h40); wr(8'h10, 8'h77);
    wait_ready(n);
    rd(8'h00, v); chk("R9 status after refused setup", v, 8'h80);
    wr(8'h00, 8'hFF);
    rd(8'h10, v); chk("R9 refused program left array", v, exp_mem[8'h10]);

    // R12: programming supply absent
    busy_cycles = 8'd3;
    prog_inhibit = 1'b1;
    wr(8'h11, 8'h40); wr(8'h11, 8'h00);
    chk("R12 no request", {7'd0, op_valid}, 8'h00);
    rd(8'h00, v); chk("R12 program inhibited", v, 8'h98);
    wr(8'h00, 8'h50);
    wr(8'h11, 8'h20); wr(8'h11, 8'hD0);
    rd(8'h00, v); chk("R12 erase inhibited", v, 8'hA8);
    wr(8'h00, 8'h50);
    prog_inhibit = 1'b0;

    // R13: reset during an erase
    busy_cycles = 8'd40;
    wr(8'hE3, 8'h20); wr(8'hE3, 8'hD0);
    for (int i = 8'hE0; i < 8'hF0; i++) exp_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    do_reset();
    rd(8'h05, v); chk("R13 array mode after abort", v, exp_mem[5]);
    wr(8'h00, 8'h70); rd(8'h00, v); chk("R13 status after abort", v, 8'h80);
    busy_cycles = 8'd2;
    wr(8'h05, 8'h40); wr(8'h05, 8'hAB);
    exp_mem[5] = 8'hAB;
    wait_ready(n); chk("R13 engine usable after abort", 8'(n), 8'd3);

    // Final array image
    wr(8'h00, 8'hFF);
    for (int i = 0; i < 256; i++) begin
      rd(8'(i), v); chk($sformatf("R4 R5 final byte %h", i[7:0]), v, exp_mem[i]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule